// File: doc/BRIEF.md
# Delayed Sequence Match Detector

This block watches two one-bit streams that share one clock. The first stream, A, is expected to carry random data. The second stream, B, should be A delayed by a whole number of cycles, somewhere from 1 to 10. The block does not know the delay in advance. It tests every candidate delay in parallel against a single shared record of past A samples. It raises a match flag once B has agreed with at least one candidate on every comparison made since reset.

A candidate delay stays alive for as long as B agrees with the matching history tap. It is dropped for good on its first disagreement. Only a reset brings it back. The match output waits for a warm-up period so that a short, lucky agreement is not reported. Next to the flag, the block reports the smallest delay that is still alive. A system can use this to confirm a loop-back or a delay line and to find its length.

Top module: `lag_match_det`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, the history and the comparison counters are cleared and every candidate delay is marked consistent. From that edge on, `match_o` reads 0 and `lag_o` reads 0.
- R2: Comparisons against candidate k use B sampled at edge n and A sampled at edge n−k. They start only once k samples of A have been captured since reset. B values seen before that are ignored for candidate k.
- R3: A candidate is eliminated on the first edge where B differs from its delayed A. It stays eliminated until the next reset, even if B later follows a different delay.
- R4: `match_o` stays 0 until 10 comparison edges have occurred with the full 10-deep history. Counting edges from reset release, the first of these comparison edges is the 11th. `match_o` can therefore first read 1 just after the 20th edge.
- R5: After the warm-up, `match_o` is 1 whenever at least one candidate from 1 to 10 is still consistent. A true delayed copy of A therefore holds it at 1.
- R6: `lag_o` gives the smallest still-consistent delay as an unsigned binary number from 1 to 10 while `match_o` is 1. It reads 0 while `match_o` is 0.
- R7: When B is unrelated to A, or is delayed by more than 10 cycles, `match_o` falls to 0 once random data has made every candidate disagree.
- R8: A reset in the middle of a stream re-arms all candidates, so a new delay can be detected afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| a_in | input | 1 | Reference bit stream A |
| b_in | input | 1 | Stream B, expected to be a delayed copy of A |
| match_o | output | 1 | B is consistent with some delay from 1 to 10 (after warm-up) |
| lag_o | output | 4 | Smallest consistent delay, 0 when there is no match |

## Verification
The hardest state to reach from the ports is a candidate that B contradicts and that must stay dead. A random stream hides this, because random B almost always kills every candidate anyway. The bench therefore locks on to one delay, then switches B to a second delay whose candidate was already killed earlier. The switch must drop the match, not move it. A second directed case drives junk on B during the fill period before the deepest tap becomes valid. That case shows that comparisons are held back until the history behind them exists.

// File: rtl/lmd_pkg.sv
// Shared constants for the delayed sequence match detector.
package lmd_pkg;
    localparam int LMD_MAX_LAG  = 10;  // deepest candidate delay
    localparam int LMD_WARM_CMP = 10;  // full-history comparisons before reporting
endpackage

// File: rtl/lmd_history.sv
// Shift register of past A samples plus a saturating fill count.
// Tap index k-1 holds A from k edges ago; fill_o says how many taps are valid.
// Assumes MAX_LAG >= 2.
module lmd_history #(
    parameter int MAX_LAG = lmd_pkg::LMD_MAX_LAG,
    parameter int FILL_W  = $clog2(MAX_LAG + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               a_in,
    output logic [MAX_LAG-1:0] taps_o,
    output logic [FILL_W-1:0]  fill_o
);
    localparam logic [FILL_W-1:0] FILL_MAX = FILL_W'(MAX_LAG);

    logic [MAX_LAG-1:0] taps_q;
    logic [FILL_W-1:0]  fill_q;

    // Shift the newest A sample into tap 0 on every edge.
    always_ff @(posedge clk) begin
        if (!rst_n) taps_q <= '0;
        else        taps_q <= {taps_q[MAX_LAG-2:0], a_in};
    end

    // Count captured samples, stopping at the history depth.
    always_ff @(posedge clk) begin
        if (!rst_n)                fill_q <= '0;
        else if (fill_q != FILL_MAX) fill_q <= fill_q + 1'b1;
    end

    assign taps_o = taps_q;
    assign fill_o = fill_q;
endmodule

// File: rtl/lmd_tracker.sv
// Consistency flag for one candidate delay. Set by reset, cleared for good
// on the first armed mismatch between B and the candidate's history tap.
module lmd_tracker (
    input  logic clk,
    input  logic rst_n,
    input  logic armed_i,
    input  logic tap_i,
    input  logic b_in,
    output logic ok_o
);
    logic ok_q;

    // Drop the candidate on a valid mismatch; only reset restores it.
    always_ff @(posedge clk) begin
        if (!rst_n)                          ok_q <= 1'b1;
        else if (armed_i && (b_in != tap_i)) ok_q <= 1'b0;
    end

    assign ok_o = ok_q;
endmodule

// File: rtl/lmd_warmup.sv
// Counts comparison edges taken with a full history and flags when enough
// have passed to trust the candidate flags.
module lmd_warmup #(
    parameter int WARM_CMP = lmd_pkg::LMD_WARM_CMP
) (
    input  logic clk,
    input  logic rst_n,
    input  logic full_i,
    output logic done_o
);
    localparam int CNT_W = $clog2(WARM_CMP + 1);
    localparam logic [CNT_W-1:0] CNT_END = CNT_W'(WARM_CMP);

    logic [CNT_W-1:0] cnt_q;

    // Advance once per full-history edge, saturating at the target.
    always_ff @(posedge clk) begin
        if (!rst_n)                          cnt_q <= '0;
        else if (full_i && cnt_q != CNT_END) cnt_q <= cnt_q + 1'b1;
    end

    assign done_o = (cnt_q == CNT_END);
endmodule

// File: rtl/lmd_select.sv
// Combines candidate flags into the match flag and picks the smallest
// surviving delay. Output is zero whenever there is no match.
module lmd_select #(
    parameter int MAX_LAG = lmd_pkg::LMD_MAX_LAG,
    parameter int LAG_W   = $clog2(MAX_LAG + 1)
) (
    input  logic [MAX_LAG-1:0] ok_i,
    input  logic               done_i,
    output logic               match_o,
    output logic [LAG_W-1:0]   lag_o
);
    logic [LAG_W-1:0] low_lag;

    // Priority pick: scanning downward leaves the smallest live delay.
    always_comb begin
        low_lag = '0;
        for (int k = MAX_LAG; k >= 1; k--) begin
            if (ok_i[k-1]) low_lag = LAG_W'(k);
        end
    end

    assign match_o = done_i && (|ok_i);
    assign lag_o   = match_o ? low_lag : '0;
endmodule

// File: rtl/lag_match_det.sv
// Top of the delayed sequence match detector. Tests all candidate delays
// 1..MAX_LAG at once against one shared history of A. Assumes A and B are
// synchronous to clk; reset is synchronous, active low.
module lag_match_det #(
    parameter int MAX_LAG  = lmd_pkg::LMD_MAX_LAG,
    parameter int WARM_CMP = lmd_pkg::LMD_WARM_CMP,
    parameter int LAG_W    = $clog2(MAX_LAG + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             a_in,
    input  logic             b_in,
    output logic             match_o,
    output logic [LAG_W-1:0] lag_o
);
    localparam int FILL_W = $clog2(MAX_LAG + 1);

    logic [MAX_LAG-1:0] tap_vec;
    logic [FILL_W-1:0]  fill;
    logic [MAX_LAG-1:0] ok_vec;
    logic               warm_done;

    lmd_history #(.MAX_LAG(MAX_LAG), .FILL_W(FILL_W)) u_hist (
        .clk(clk), .rst_n(rst_n), .a_in(a_in),
        .taps_o(tap_vec), .fill_o(fill)
    );

    // One tracker per candidate delay, armed once its tap holds real data.
    for (genvar g = 0; g < MAX_LAG; g++) begin : g_cand
        lmd_tracker u_trk (
            .clk(clk), .rst_n(rst_n),
            .armed_i(fill >= FILL_W'(g + 1)),
            .tap_i(tap_vec[g]), .b_in(b_in),
            .ok_o(ok_vec[g])
        );
    end

    lmd_warmup #(.WARM_CMP(WARM_CMP)) u_warm (
        .clk(clk), .rst_n(rst_n),
        .full_i(fill == FILL_W'(MAX_LAG)),
        .done_o(warm_done)
    );

    lmd_select #(.MAX_LAG(MAX_LAG), .LAG_W(LAG_W)) u_sel (
        .ok_i(ok_vec), .done_i(warm_done),
        .match_o(match_o), .lag_o(lag_o)
    );
endmodule

// File: rtl/lmd_checker.sv
// Temporal checks for lag_match_det, attached with bind.
module lmd_checker #(
    parameter int MAX_LAG  = 10,
    parameter int WARM_CMP = 10,
    parameter int LAG_W    = 4,
    parameter int FILL_W   = 4
) (
    input logic               clk,
    input logic               rst_n,
    input logic               a_in,
    input logic               match_o,
    input logic [LAG_W-1:0]   lag_o,
    input logic [MAX_LAG-1:0] ok_vec,
    input logic [MAX_LAG-1:0] tap_vec,
    input logic [FILL_W-1:0]  fill
);
    localparam int EDGE_END = MAX_LAG + WARM_CMP;
    localparam int EDGE_W   = $clog2(EDGE_END + 1);

    logic [EDGE_W-1:0] edges_q;

    // Independent count of edges since reset release, saturating.
    always_ff @(posedge clk) begin
        if (!rst_n)                          edges_q <= '0;
        else if (edges_q != EDGE_W'(EDGE_END)) edges_q <= edges_q + 1'b1;
    end

    // R1
    reset_clears_chk: assert property (@(posedge clk)
        !rst_n |=> (!match_o && lag_o == '0 && fill == '0 && &ok_vec));

    // R2
    tap_newest_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fill != '0) |-> (tap_vec[0] == $past(a_in)));

    // R2
    tap_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fill != '0) |-> (tap_vec[MAX_LAG-1:1] == $past(tap_vec[MAX_LAG-2:0])));

    // R3
    no_revive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((ok_vec & ~$past(ok_vec)) == '0));

    // R4
    warmup_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        match_o |-> (edges_q == EDGE_W'(EDGE_END)));

    // R6
    lag_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        match_o |-> (lag_o != '0 && lag_o <= LAG_W'(MAX_LAG) && ok_vec[lag_o - 1'b1]));

    // R6
    lag_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !match_o |-> (lag_o == '0));
endmodule

bind lag_match_det lmd_checker #(
    .MAX_LAG(MAX_LAG), .WARM_CMP(WARM_CMP), .LAG_W(LAG_W), .FILL_W(FILL_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .a_in(a_in), .match_o(match_o),
    .lag_o(lag_o), .ok_vec(ok_vec), .tap_vec(tap_vec), .fill(fill)
);

// File: tb/tb_lag_match_det.sv
module tb_lag_match_det;
    localparam int MAX_LAG = 10;
    localparam int WARM    = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       a_in = 1'b0;
    logic       b_in = 1'b0;
    logic       match_o;
    logic [3:0] lag_o;

    int checks = 0;
    int errors = 0;

    // Reference model state, written from the requirements.
    bit m_ok   [1:MAX_LAG];
    bit m_hist [1:MAX_LAG];
    int m_fill;
    int m_cmp;
    bit s_buf  [0:15];

    always #10 clk = ~clk;

    lag_match_det dut (
        .clk(clk), .rst_n(rst_n), .a_in(a_in), .b_in(b_in),
        .match_o(match_o), .lag_o(lag_o)
    );

    function automatic void model_reset();
        for (int k = 1; k <= MAX_LAG; k++) begin
            m_ok[k] = 1'b1;
            m_hist[k] = 1'b0;
        end
        m_fill = 0;
        m_cmp = 0;
    endfunction

    function automatic void model_edge(bit a, bit b);
        for (int k = 1; k <= MAX_LAG; k++)
            if (m_fill >= k && b != m_hist[k]) m_ok[k] = 1'b0;
        if (m_fill >= MAX_LAG && m_cmp < WARM) m_cmp++;
        for (int k = MAX_LAG; k >= 2; k--) m_hist[k] = m_hist[k-1];
        m_hist[1] = a;
        if (m_fill < MAX_LAG) m_fill++;
    endfunction

    function automatic bit exp_match();
        bit any = 1'b0;
        for (int k = 1; k <= MAX_LAG; k++) any |= m_ok[k];
        return (m_cmp == WARM) && any;
    endfunction

    function automatic int exp_lag();
        if (!exp_match()) return 0;
        for (int k = 1; k <= MAX_LAG; k++) if (m_ok[k]) return k;
        return 0;
    endfunction

    task automatic chk(string req, int got, int exp);
        checks++;
        if (got != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, got, exp, $time);
        end
    endtask

    task automatic check_out(string req);
        chk(req, int'(match_o), int'(exp_match()));
        chk(req, int'(lag_o), exp_lag());
    endtask

    // Drive one edge's inputs at a falling edge and advance to the next one.
    task automatic step(bit a, bit b, bit run);
        rst_n = run;
        a_in = a;
        b_in = b;
        for (int j = 15; j >= 1; j--) s_buf[j] = s_buf[j-1];
        s_buf[0] = a;
        if (!run) model_reset();
        else      model_edge(a, b);
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic do_reset();
        step(1'b0, 1'b0, 1'b0);
        step(1'b0, 1'b0, 1'b0);
    endtask

    // B follows A by d edges; d = 0 makes B independent random data.
    task automatic run_delay(int d, int n, string req);
        for (int i = 0; i < n; i++) begin
            bit a = 1'($urandom);
            bit b = (d == 0) ? 1'($urandom) : s_buf[d-1];
            step(a, b, 1'b1);
            check_out(req);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=expired expected=finished");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd48611));
        for (int j = 0; j < 16; j++) s_buf[j] = 1'b0;
        @(negedge clk);
        do_reset();
        // R1 reset state
        chk("R1", int'(match_o), 0);
        chk("R1", int'(lag_o), 0);

        // R4 warm-up timing with an all-zero stream (every delay fits)
        for (int i = 1; i <= 25; i++) begin
            step(1'b0, 1'b0, 1'b1);
            chk("R4", int'(match_o), (i >= 20) ? 1 : 0);
            check_out("R4");
        end
        chk("R6", int'(lag_o), 1);

        // R5 / R6 each delay in range on random data
        for (int d = 1; d <= MAX_LAG; d++) begin
            do_reset();
            run_delay(d, 45, "R5");
            chk("R5", int'(match_o), 1);
            chk("R6", int'(lag_o), d);
        end

        // R2 junk on B before the deepest tap is valid is ignored for delay 10
        do_reset();
        for (int i = 0; i < MAX_LAG; i++) begin
            step(1'($urandom), 1'b1, 1'b1);
            check_out("R2");
        end
        run_delay(10, 40, "R2");
        chk("R2", int'(lag_o), 10);

        // R3 switching to a delay already ruled out does not revive a match
        do_reset();
        run_delay(3, 40, "R3");
        chk("R3", int'(lag_o), 3);
        run_delay(6, 40, "R3");
        chk("R3", int'(match_o), 0);

        // R7 delay beyond range and unrelated B
        do_reset();
        run_delay(11, 60, "R7");
        chk("R7", int'(match_o), 0);
        do_reset();
        run_delay(0, 60, "R7");
        chk("R7", int'(match_o), 0);

        // R8 mid-stream reset re-arms detection
        do_reset();
        check_out("R8");
        run_delay(4, 40, "R8");
        chk("R8", int'(match_o), 1);
        chk("R8", int'(lag_o), 4);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule